// File: doc/BRIEF.md
# Dual-Rail Completion Detector

This block watches an n-bit bus in which every bit travels on a pair of wires, a true rail and a false rail. A pair with one rail high carries a value; a pair with both rails low is the spacer that separates successive data items. The detector raises `done` once every bit carries a value. It lowers `done` once every bit has gone back to the spacer. While the bus is partly filled or partly drained, `done` keeps its last value. Handshake logic uses this output to decide when the stage ahead may precharge or evaluate.

Each bit gets a presence term, the inverse of the NOR of its two rails. The presence terms feed a tree of two-input Muller C-elements. Each C-element is modelled as a clocked cell that holds its state. When a level has an odd number of inputs, the leftover input is carried up through a one-input cell. Every path through the tree therefore has the same number of registers.

A build-time mode selects an asymmetric variant. In that mode the tree still sets only when every bit is present. It clears on the clock after the precharge control `pc` goes low, whether or not the bus has returned to the spacer.

Top module: `dual_rail_done_tree`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, `done` is 0 in both modes.
- R2: A bit counts as present when either of its rails is 1: (true,false) = (1,0) means 1, (0,1) means 0, and (1,1) also counts as present. A bit counts as absent only in the spacer code (0,0).
- R3: In symmetric mode, `done` rises exactly DEPTH clock edges after the edge at which the last bit becomes present. DEPTH is ceil(log2(WIDTH)), which is 3 for the default WIDTH of 5. The data values carried have no influence on this timing.
- R4: In symmetric mode, `done` falls exactly DEPTH clock edges after the edge at which the last bit returns to the spacer.
- R5: While some bits are present and others are absent, `done` keeps its previous value, whether it was 0 or 1.
- R6: Each C-element cell sets when all its inputs are 1, clears when all are 0 (symmetric mode), and otherwise keeps its state.
- R7: An odd leftover input is passed up through a one-input cell. The latency is therefore DEPTH no matter which bit arrives or leaves last, including the highest bit.
- R8: In asymmetric mode, `done` rises DEPTH edges after the bus is fully present, but only while `pc` is 1. While `pc` is 0, `done` stays 0 even with a full bus.
- R9: In asymmetric mode, `done` is 0 on the edge after any edge at which `pc` is 0, even when every bit is still present.
- R10: In asymmetric mode with `pc` at 1, the bus returning to the spacer does not clear `done`.
- R11: In symmetric mode, `pc` has no effect on `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the state-holding cells |
| rst_n | input | 1 | Synchronous active-low reset, clears every cell |
| rail_t | input | WIDTH | True rail of each bus bit |
| rail_f | input | WIDTH | False rail of each bus bit |
| pc | input | 1 | Precharge control; a low level clears the tree in asymmetric mode |
| done | output | 1 | Completion indication from the root of the tree |

## Verification
The assertions check the C-element rule of every cell on every cycle: set when all inputs are high, clear when all are low, hold when they are mixed. They also check the forced clear from a low `pc` in asymmetric mode. At the top, they check that a rise of `done` is always preceded by a full bus, and a symmetric fall by an empty one. The exact DEPTH-edge latency, the independence of that latency from which bit arrives last (including the odd leftover bit), and the holding of `done` through staggered arrivals and removals only show up in the bench's directed scenarios. The same is true of the isolation of the symmetric mode from `pc`.

// File: rtl/dcd_pkg.sv
package dcd_pkg;

    typedef enum logic {
        DCD_SYMMETRIC  = 1'b0,
        DCD_ASYMMETRIC = 1'b1
    } dcd_mode_e;

    typedef struct packed {
        logic state;
    } cell_regs_t;

    typedef struct packed {
        logic seen_full;
        logic seen_empty;
    } watch_regs_t;

    // Number of nodes at tree level lvl (level 0 = leaves).
    function automatic int level_width(input int n, input int lvl);
        int w;
        w = n;
        for (int k = 0; k < lvl; k++) begin
            w = (w + 1) / 2;
        end
        return w;
    endfunction

    // Number of cell levels between the leaves and the root.
    function automatic int tree_depth(input int n);
        int w;
        int d;
        w = n;
        d = 0;
        while (w > 1) begin
            w = (w + 1) / 2;
            d++;
        end
        return d;
    endfunction

    // Position of the first node of level lvl in the flat node vector.
    function automatic int level_offset(input int n, input int lvl);
        int off;
        off = 0;
        for (int k = 0; k < lvl; k++) begin
            off += level_width(n, k);
        end
        return off;
    endfunction

    function automatic int node_total(input int n);
        return level_offset(n, tree_depth(n) + 1);
    endfunction

endpackage

// File: rtl/dcd_rail_term.sv
module dcd_rail_term #(
    parameter int WIDTH = 5
) (
    input  logic [WIDTH-1:0] rail_t,
    input  logic [WIDTH-1:0] rail_f,
    output logic [WIDTH-1:0] present
);

    logic [WIDTH-1:0] spacer_nor;

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        // Per-bit NOR: high only for the spacer code.
        assign spacer_nor[b] = ~(rail_t[b] | rail_f[b]);
        assign present[b]    = ~spacer_nor[b];
    end

endmodule

// File: rtl/dcd_celem.sv
module dcd_celem
    import dcd_pkg::*;
#(
    parameter int        FANIN = 2,
    parameter dcd_mode_e MODE  = DCD_SYMMETRIC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pc,
    input  logic [FANIN-1:0] leg,
    output logic             out
);

    localparam bit ASYM = (MODE == DCD_ASYMMETRIC);

    cell_regs_t cell_d, cell_q;
    logic       all_high;
    logic       all_low;
    logic       force_clr;

    always_comb begin
        all_high  = &leg;
        all_low   = ~|leg;
        force_clr = ASYM && !pc;
        cell_d    = cell_q;
        if (force_clr) begin
            cell_d.state = 1'b0;
        end else if (all_high) begin
            cell_d.state = 1'b1;
        end else if (all_low && !ASYM) begin
            cell_d.state = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cell_q <= '0;
        end else begin
            cell_q <= cell_d;
        end
    end

    assign out = cell_q.state;

    p_all_high_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((!ASYM || pc) && (&leg)) |=> out);

    p_all_low_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ASYM && leg == '0) |=> !out);

    p_mixed_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((!ASYM || pc) && !(&leg) && (|leg)) |=> $stable(out));

    p_pc_low_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ASYM && !pc) |=> !out);

    p_no_spacer_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ASYM && pc && out) |=> out);

endmodule

// File: rtl/dcd_tree.sv
module dcd_tree
    import dcd_pkg::*;
#(
    parameter int        WIDTH = 5,
    parameter dcd_mode_e MODE  = DCD_SYMMETRIC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pc,
    input  logic [WIDTH-1:0] present,
    output logic             root
);

    localparam int DEPTH = tree_depth(WIDTH);
    localparam int TOTAL = node_total(WIDTH);

    logic [TOTAL-1:0] nodes;

    assign nodes[WIDTH-1:0] = present;

    for (genvar l = 1; l <= DEPTH; l++) begin : g_lvl
        localparam int PREV_W   = level_width(WIDTH, l - 1);
        localparam int THIS_W   = level_width(WIDTH, l);
        localparam int PREV_OFF = level_offset(WIDTH, l - 1);
        localparam int THIS_OFF = level_offset(WIDTH, l);
        for (genvar j = 0; j < THIS_W; j++) begin : g_cell
            // A pair when both inputs exist, otherwise the odd leftover
            // climbs through a single-input cell to keep latency uniform.
            localparam int FAN = (2 * j + 1 < PREV_W) ? 2 : 1;
            dcd_celem #(
                .FANIN (FAN),
                .MODE  (MODE)
            ) u_cell (
                .clk   (clk),
                .rst_n (rst_n),
                .pc    (pc),
                .leg   (nodes[PREV_OFF + 2 * j +: FAN]),
                .out   (nodes[THIS_OFF + j])
            );
        end
    end

    assign root = nodes[TOTAL-1];

endmodule

// File: rtl/dual_rail_done_tree.sv
module dual_rail_done_tree
    import dcd_pkg::*;
#(
    parameter int        WIDTH = 5,
    parameter dcd_mode_e MODE  = DCD_SYMMETRIC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] rail_t,
    input  logic [WIDTH-1:0] rail_f,
    input  logic             pc,
    output logic             done
);

    localparam bit ASYM = (MODE == DCD_ASYMMETRIC);

    logic [WIDTH-1:0] present;
    logic             all_present;
    logic             all_spacer;
    watch_regs_t      watch_d, watch_q;

    dcd_rail_term #(
        .WIDTH (WIDTH)
    ) u_rail_term (
        .rail_t  (rail_t),
        .rail_f  (rail_f),
        .present (present)
    );

    dcd_tree #(
        .WIDTH (WIDTH),
        .MODE  (MODE)
    ) u_tree (
        .clk     (clk),
        .rst_n   (rst_n),
        .pc      (pc),
        .present (present),
        .root    (done)
    );

    // History of the bus since the last change of done, for the checks below.
    always_comb begin
        all_present = &present;
        all_spacer  = ~|present;
        watch_d     = watch_q;
        if (all_present) begin
            watch_d.seen_full = 1'b1;
        end else if (done) begin
            watch_d.seen_full = 1'b0;
        end
        if (all_spacer) begin
            watch_d.seen_empty = 1'b1;
        end else if (!done) begin
            watch_d.seen_empty = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            watch_q <= '0;
        end else begin
            watch_q <= watch_d;
        end
    end

    p_rise_needs_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> watch_q.seen_full);

    p_fall_needs_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ASYM && $fell(done)) |-> watch_q.seen_empty);

    p_pc_low_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ASYM && !pc) |=> !done);

    p_reset_done_r1: assert property (@(posedge clk)
        !rst_n |=> !done);

endmodule

// File: tb/dual_rail_done_tree_tb.sv
module dual_rail_done_tree_tb;
    import dcd_pkg::*;

    localparam int W     = 5;
    localparam int DEPTH = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] rt = '0;
    logic [W-1:0] rf = '0;
    logic         pc = 1'b1;
    logic         done;
    logic         done_a;
    int           checks = 0;
    int           errors = 0;

    always #5 clk = ~clk;

    dual_rail_done_tree #(.WIDTH(W), .MODE(DCD_SYMMETRIC)) u_dut (
        .clk(clk), .rst_n(rst_n), .rail_t(rt), .rail_f(rf), .pc(pc), .done(done));

    dual_rail_done_tree #(.WIDTH(W), .MODE(DCD_ASYMMETRIC)) u_dut_asym (
        .clk(clk), .rst_n(rst_n), .rail_t(rt), .rail_f(rf), .pc(pc), .done(done_a));

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic drive_bit(input int i, input logic v);
        rt[i] = v;
        rf[i] = ~v;
    endtask

    task automatic spacer_bit(input int i);
        rt[i] = 1'b0;
        rf[i] = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 sym reset", done, 1'b0);
        check("R1 asym reset", done_a, 1'b0);
        rst_n = 1'b1;
        step();
        check("R1 sym after release", done, 1'b0);
        check("R1 asym after release", done_a, 1'b0);
    endtask

    // Staggered arrival then staggered removal, bit indices packed 3 bits each.
    task automatic t_sym_stagger(input string tag, input logic [14:0] order,
                                 input logic [W-1:0] data);
        pc = 1'b1;
        for (int k = 0; k < W - 1; k++) begin
            drive_bit(int'(order[3*k +: 3]), data[order[3*k +: 3]]);
            step();
            check({"R5 hold low ", tag}, done, 1'b0);
        end
        for (int k = 0; k < DEPTH + 1; k++) begin
            step();
            check({"R5 partial stays low ", tag}, done, 1'b0);
        end
        drive_bit(int'(order[12 +: 3]), data[order[12 +: 3]]);
        for (int k = 0; k < DEPTH - 1; k++) begin
            step();
            check({"R3 not yet ", tag}, done, 1'b0);
        end
        step();
        check({"R3 rise ", tag}, done, 1'b1);
        for (int k = 0; k < W - 1; k++) begin
            spacer_bit(int'(order[3*k +: 3]));
            step();
            check({"R5 hold high ", tag}, done, 1'b1);
        end
        for (int k = 0; k < DEPTH + 1; k++) begin
            step();
            check({"R5 partial stays high ", tag}, done, 1'b1);
        end
        spacer_bit(int'(order[12 +: 3]));
        for (int k = 0; k < DEPTH - 1; k++) begin
            step();
            check({"R4 not yet ", tag}, done, 1'b1);
        end
        step();
        check({"R4 fall ", tag}, done, 1'b0);
    endtask

    // R2: the (1,1) code counts as present, spacer as absent.
    task automatic t_code_values();
        pc = 1'b1;
        for (int i = 0; i < W; i++) drive_bit(i, i[0]);
        rt[2] = 1'b1;
        rf[2] = 1'b1;
        for (int k = 0; k < DEPTH; k++) step();
        check("R2 both rails high counts present", done, 1'b1);
        spacer_bit(2);
        for (int k = 0; k < DEPTH + 2; k++) step();
        check("R2 single spacer keeps done", done, 1'b1);
        for (int i = 0; i < W; i++) spacer_bit(i);
        for (int k = 0; k < DEPTH; k++) step();
        check("R2 spacer counts absent", done, 1'b0);
    endtask

    // R8, R9, R10, R11 on the asymmetric instance alongside the symmetric one.
    task automatic t_asym_flow();
        pc = 1'b0;
        step();
        check("R9 pc low clears", done_a, 1'b0);
        pc = 1'b1;
        step();
        for (int i = W - 1; i >= 0; i--) begin
            drive_bit(i, 1'b1);
            if (i > 0) begin
                step();
                check("R8 partial no set", done_a, 1'b0);
            end
        end
        for (int k = 0; k < DEPTH - 1; k++) begin
            step();
            check("R8 not yet", done_a, 1'b0);
        end
        step();
        check("R8 set with pc high", done_a, 1'b1);
        for (int i = 0; i < W; i++) spacer_bit(i);
        for (int k = 0; k < DEPTH + 2; k++) step();
        check("R10 spacer does not clear", done_a, 1'b1);
        check("R4 sym clears on spacer", done, 1'b0);
        pc = 1'b0;
        step();
        check("R9 clear on pc low", done_a, 1'b0);
    endtask

    task automatic t_asym_pc_block();
        pc = 1'b0;
        for (int i = 0; i < W; i++) drive_bit(i, 1'b0);
        for (int k = 0; k < DEPTH + 2; k++) step();
        check("R8 pc low blocks set", done_a, 1'b0);
        check("R11 sym ignores pc low", done, 1'b1);
        pc = 1'b1;
        for (int k = 0; k < DEPTH - 1; k++) begin
            step();
            check("R8 not yet after pc high", done_a, 1'b0);
        end
        step();
        check("R8 set after pc high", done_a, 1'b1);
        pc = 1'b0;
        step();
        check("R9 clear with bus full", done_a, 1'b0);
        check("R11 sym unaffected", done, 1'b1);
        for (int i = 0; i < W; i++) spacer_bit(i);
        for (int k = 0; k < DEPTH; k++) step();
        check("R11 sym falls with pc low", done, 1'b0);
        pc = 1'b1;
        step();
    endtask

    initial begin
        #(100000 * 10);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        // R7: leftover bit 4 arrives and leaves last.
        t_sym_stagger("R7 last=4", {3'd4, 3'd3, 3'd2, 3'd1, 3'd0}, 5'b10110);
        // Bit 4 first, bit 0 last, other data.
        t_sym_stagger("R7 last=0", {3'd0, 3'd1, 3'd2, 3'd3, 3'd4}, 5'b01001);
        t_sym_stagger("R3 interleaved", {3'd2, 3'd4, 3'd0, 3'd3, 3'd1}, 5'b00000);
        t_code_values();
        t_asym_flow();
        t_asym_pc_block();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule